// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block sits between a processor's load/store port and one AXI4 master port. It holds recently used memory lines in two ways of tag and data storage. Stores are kept in the cache and reach memory only when their line is chosen for eviction. A miss of either kind, load or store, first brings the whole line in from memory. A store miss then merges its bytes into the line that was just fetched.

The processor side is a request/accept pair with a one-cycle registered response. A request stays on the inputs until `req_accept` is sampled high. The memory side issues incrementing bursts of whole lines for fills and evictions.

Two parameters set an address window. Requests whose byte address falls outside the window never touch the storage. They go out as single-beat bus transactions, and the block waits for the bus to answer before it accepts the request. The default geometry holds 16KB: 2 ways × 256 sets × 8 words of 32 bits.

Top module: `dcache_wb`

## Requirements
- R1: While reset is asserted and right after it is released, `req_accept`, `resp_valid`, `m_arvalid`, `m_awvalid` and `m_wvalid` are all low.
- R2: A load that hits is accepted in the cycle it is presented, with no bus transaction. Its response carries the word most recently stored at that address.
- R3: A load miss inside the window issues exactly one read burst. The burst has `m_arburst` = 2'b01 (incrementing), `m_arlen` = LINE_WORDS-1, and `m_araddr` set to the line-aligned address. The response then returns the requested word.
- R4: A store is never written through to memory. A store miss allocates the line with one read burst first. In the merged word, each byte whose `req_wstrb` bit (bit n covers data bits 8n+7:8n) is set takes the store data, and every other byte keeps its earlier value.
- R5: When a miss selects a dirty victim, the block writes the victim back before it fills the line. The write burst goes to the victim's line-aligned address, has `m_awlen` = LINE_WORDS-1, and sets `m_wlast` only on the last beat. The write response must be received before the fill's read address is issued. Afterwards memory holds the cached contents of that line.
- R6: Evicting a clean line causes no write transaction.
- R7: The victim is an invalid way if one exists. Otherwise it is the way of the set that was accessed less recently.
- R8: A request whose address is below CACHE_LO or above CACHE_HI goes out as a single-beat transaction (`m_arlen` or `m_awlen` = 0). Its address is the request address with bits 1:0 cleared, and a store carries `req_wstrb`. Loads return the bus data. These requests never allocate, so repeating one goes to the bus again.
- R9: `req_accept` is only high with `req_valid`, and never while a read address, write address or write data is pending on the bus. `resp_valid` pulses exactly one cycle after each accept.
- R10: Once `m_arvalid` or `m_awvalid` is raised, it stays high with a stable address and length until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wstrb | input | 4 | Byte enables for a store |
| req_wdata | input | 32 | Store data |
| req_accept | output | 1 | Request taken at this clock edge |
| resp_valid | output | 1 | Response for the last accepted request |
| resp_rdata | output | 32 | Load data |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awburst | output | 2 | Write burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arburst | output | 2 | Read burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rlast | input | 1 | Last read beat |

## Verification
The properties assume that the processor holds every request field steady until it sees an accept. They also assume that the memory side follows the bus rules. Read data and write responses come only after their address handshake. A write response comes only after the beat marked last. A fill returns exactly the requested number of beats with last on the final one. The bench's slave model is built to those rules: it stalls its ready signals in a fixed rotating pattern but never sends unrequested data. The processor tasks change request fields only after an accept has been taken.

// File: rtl/dcache_wb.sv
`timescale 1ns/1ps
module dcache_wb #(
  parameter int SETS = 256,
  parameter int LINE_WORDS = 8,
  parameter logic [31:0] CACHE_LO = 32'h0000_0000,
  parameter logic [31:0] CACHE_HI = 32'h7fff_ffff
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [31:0] req_addr,
  input  logic [3:0]  req_wstrb,
  input  logic [31:0] req_wdata,
  output logic        req_accept,
  output logic        resp_valid,
  output logic [31:0] resp_rdata,
  output logic        m_awvalid,
  input  logic        m_awready,
  output logic [31:0] m_awaddr,
  output logic [7:0]  m_awlen,
  output logic [1:0]  m_awburst,
  output logic        m_wvalid,
  input  logic        m_wready,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_wstrb,
  output logic        m_wlast,
  input  logic        m_bvalid,
  output logic        m_bready,
  output logic        m_arvalid,
  input  logic        m_arready,
  output logic [31:0] m_araddr,
  output logic [7:0]  m_arlen,
  output logic [1:0]  m_arburst,
  input  logic        m_rvalid,
  output logic        m_rready,
  input  logic [31:0] m_rdata,
  input  logic        m_rlast
);
  localparam int WB   = $clog2(LINE_WORDS);
  localparam int OFS  = WB + 2;
  localparam int IDX  = $clog2(SETS);
  localparam int TAGW = 32 - OFS - IDX;
  localparam int DAW  = 1 + IDX + WB;

  typedef enum logic [3:0] {IDLE, WB_AW, WB_W, WB_B, RF_AR, RF_R,
                            UN_AW, UN_W, UN_B, UN_AR, UN_R} st_t;
  st_t st;

  logic [TAGW-1:0]   tag_q [2][SETS];
  logic [31:0]       dat_q [2**DAW];
  logic [1:0][SETS-1:0] vld_q, dty_q;
  logic [SETS-1:0]   lru_q;
  logic              vic_q;
  logic [WB-1:0]     beat_q;

  wire [IDX-1:0]  idx  = req_addr[OFS+IDX-1:OFS];
  wire [TAGW-1:0] tag  = req_addr[31:OFS+IDX];
  wire [WB-1:0]   wsel = req_addr[OFS-1:2];
  wire [31:0]     waddr = req_addr & 32'hffff_fffc;

  wire hit0 = vld_q[0][idx] && tag_q[0][idx] == tag;
  wire hit1 = vld_q[1][idx] && tag_q[1][idx] == tag;
  wire cacheable = req_addr >= CACHE_LO && req_addr <= CACHE_HI;
  wire victim = !vld_q[0][idx] ? 1'b0 : !vld_q[1][idx] ? 1'b1 : lru_q[idx];
  wire hit_go = st == IDLE && req_valid && cacheable && (hit0 || hit1);
  wire last_beat = beat_q == WB'(LINE_WORDS - 1);

  wire [DAW-1:0] hit_ix = {hit1, idx, wsel};
  wire [DAW-1:0] vic_ix = {vic_q, idx, beat_q};

  assign req_accept = hit_go || (st == UN_B && m_bvalid) || (st == UN_R && m_rvalid);

  assign m_awvalid = st == WB_AW || st == UN_AW;
  assign m_awaddr  = st == UN_AW ? waddr : {tag_q[vic_q][idx], idx, {OFS{1'b0}}};
  assign m_awlen   = st == UN_AW ? 8'd0 : 8'(LINE_WORDS - 1);
  assign m_awburst = 2'b01;
  assign m_wvalid  = st == WB_W || st == UN_W;
  assign m_wdata   = st == UN_W ? req_wdata : dat_q[vic_ix];
  assign m_wstrb   = st == UN_W ? req_wstrb : 4'hf;
  assign m_wlast   = st == UN_W || last_beat;
  assign m_bready  = st == WB_B || st == UN_B;
  assign m_arvalid = st == RF_AR || st == UN_AR;
  assign m_araddr  = st == UN_AR ? waddr : {tag, idx, {OFS{1'b0}}};
  assign m_arlen   = st == UN_AR ? 8'd0 : 8'(LINE_WORDS - 1);
  assign m_arburst = 2'b01;
  assign m_rready  = st == RF_R || st == UN_R;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      beat_q <= '0;
      vic_q <= 1'b0;
      vld_q <= '0;
      dty_q <= '0;
      lru_q <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_accept;
      if (req_accept) resp_rdata <= st == UN_R ? m_rdata : st == UN_B ? 32'h0 : dat_q[hit_ix];
      unique case (st)
        IDLE: if (req_valid) begin
          if (!cacheable) st <= req_we ? UN_AW : UN_AR;
          else if (hit_go) begin
            lru_q[idx] <= ~hit1;
            if (req_we) dty_q[hit1][idx] <= 1'b1;
          end else begin
            vic_q <= victim;
            beat_q <= '0;
            st <= (vld_q[victim][idx] && dty_q[victim][idx]) ? WB_AW : RF_AR;
          end
        end
        WB_AW: if (m_awready) st <= WB_W;
        WB_W: if (m_wready) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) st <= WB_B;
        end
        WB_B: if (m_bvalid) begin
          dty_q[vic_q][idx] <= 1'b0;
          st <= RF_AR;
        end
        RF_AR: if (m_arready) st <= RF_R;
        RF_R: if (m_rvalid) begin
          beat_q <= beat_q + 1'b1;
          if (m_rlast) begin
            vld_q[vic_q][idx] <= 1'b1;
            dty_q[vic_q][idx] <= 1'b0;
            st <= IDLE;
          end
        end
        UN_AW: if (m_awready) st <= UN_W;
        UN_W:  if (m_wready) st <= UN_B;
        UN_B:  if (m_bvalid) st <= IDLE;
        UN_AR: if (m_arready) st <= UN_R;
        UN_R:  if (m_rvalid) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == RF_R && m_rvalid) begin
      dat_q[vic_ix] <= m_rdata;
      if (m_rlast) tag_q[vic_q][idx] <= tag;
    end
    if (hit_go && req_we)
      for (int b = 0; b < 4; b++)
        if (req_wstrb[b]) dat_q[hit_ix][8*b +: 8] <= req_wdata[8*b +: 8];
  end
endmodule

// File: rtl/dcache_wb_chk.sv
`timescale 1ns/1ps
module dcache_wb_chk #(
  parameter int LINE_WORDS = 8,
  parameter logic [31:0] CACHE_LO = 32'h0,
  parameter logic [31:0] CACHE_HI = 32'h7fff_ffff
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_accept,
  input logic        resp_valid,
  input logic        m_awvalid,
  input logic        m_awready,
  input logic [31:0] m_awaddr,
  input logic [7:0]  m_awlen,
  input logic        m_wvalid,
  input logic        m_bvalid,
  input logic        m_bready,
  input logic        m_arvalid,
  input logic        m_arready,
  input logic [31:0] m_araddr,
  input logic [7:0]  m_arlen
);
  localparam int OFS = $clog2(LINE_WORDS) + 2;
  logic wpend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wpend <= 1'b0;
    else if (m_awvalid && m_awready) wpend <= 1'b1;
    else if (m_bvalid && m_bready) wpend <= 1'b0;

  assert_ar_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));
  assert_aw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));
  assert_resp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> resp_valid);
  assert_resp_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_accept));
  assert_accept_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> req_valid && !m_arvalid && !m_awvalid && !m_wvalid);
  assert_fill_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && m_arlen != 8'd0 |-> m_arlen == 8'(LINE_WORDS - 1) && m_araddr[OFS-1:0] == '0);
  assert_single_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && m_arlen == 8'd0 |-> m_araddr < CACHE_LO || m_araddr > CACHE_HI);
  assert_wb_before_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> !wpend && !m_awvalid);
endmodule

bind dcache_wb dcache_wb_chk #(.LINE_WORDS(LINE_WORDS), .CACHE_LO(CACHE_LO), .CACHE_HI(CACHE_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_accept(req_accept),
  .resp_valid(resp_valid), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_wvalid(m_wvalid), .m_bvalid(m_bvalid),
  .m_bready(m_bready), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_araddr(m_araddr), .m_arlen(m_arlen));

// File: tb/dcache_wb_bench.sv
`timescale 1ns/1ps
module dcache_wb_bench;
  localparam int SETS = 4;
  localparam int LW = 8;
  localparam logic [31:0] LO = 32'h0000_0000;
  localparam logic [31:0] HI = 32'h0000_3fff;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_we = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_wstrb = 0;
  logic req_accept, resp_valid;
  logic [31:0] resp_rdata;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bready;
  logic m_arvalid, m_arready, m_rvalid, m_rready, m_rlast;
  logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
  logic [7:0] m_awlen, m_arlen;
  logic [1:0] m_awburst, m_arburst;
  logic [3:0] m_wstrb;
  logic m_bvalid;

  dcache_wb #(.SETS(SETS), .LINE_WORDS(LW), .CACHE_LO(LO), .CACHE_HI(HI)) u_dcache_wb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wstrb(req_wstrb), .req_wdata(req_wdata), .req_accept(req_accept),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
    .m_awburst(m_awburst), .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
    .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
    .m_arburst(m_arburst), .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
    .m_rlast(m_rlast));

  logic [31:0] mem [8192];
  logic [31:0] ref_m [8192];
  function automatic logic [31:0] seed_word(int i);
    return (32'(i) * 32'h9e37_79b9) ^ 32'h5a5a_0000;
  endfunction

  logic [2:0] tick = 0;
  logic rd_act = 0, wr_act = 0;
  logic [31:0] rd_addr = 0, wr_addr = 0;
  logic [7:0] rd_len = 0, rd_beat = 0, wr_len = 0, wr_beat = 0;
  int ar_cnt = 0, aw_cnt = 0, ord_err = 0, wlast_err = 0, acc_err = 0;
  logic [31:0] last_araddr = 0, last_awaddr = 0;
  logic [7:0] last_arlen = 0, last_awlen = 0;
  logic [1:0] last_arburst = 0;
  logic bv = 0;

  assign m_arready = tick[1:0] != 2'd3;
  assign m_awready = tick[1:0] != 2'd1;
  assign m_wready  = wr_act && tick != 3'd5;
  assign m_rvalid  = rd_act && tick[1:0] != 2'd2;
  assign m_rdata   = mem[13'(rd_addr[14:2] + 13'(rd_beat))];
  assign m_rlast   = rd_beat == rd_len;
  assign m_bvalid  = bv;

  always @(posedge clk) begin
    tick <= tick + 1'b1;
    if (req_accept && (m_arvalid || m_awvalid || m_wvalid)) acc_err <= acc_err + 1;
    if (m_arvalid && m_arready) begin
      rd_act <= 1; rd_addr <= m_araddr; rd_len <= m_arlen; rd_beat <= 0;
      ar_cnt <= ar_cnt + 1; last_araddr <= m_araddr; last_arlen <= m_arlen;
      last_arburst <= m_arburst;
      if (wr_act || bv) ord_err <= ord_err + 1;
    end
    if (m_rvalid && m_rready) begin
      rd_beat <= rd_beat + 1;
      if (rd_beat == rd_len) rd_act <= 0;
    end
    if (m_awvalid && m_awready) begin
      wr_act <= 1; wr_addr <= m_awaddr; wr_len <= m_awlen; wr_beat <= 0;
      aw_cnt <= aw_cnt + 1; last_awaddr <= m_awaddr; last_awlen <= m_awlen;
    end
    if (m_wvalid && m_wready) begin
      for (int b = 0; b < 4; b++)
        if (m_wstrb[b]) mem[13'(wr_addr[14:2] + 13'(wr_beat))][8*b +: 8] <= m_wdata[8*b +: 8];
      wr_beat <= wr_beat + 1;
      if (m_wlast != (wr_beat == wr_len)) wlast_err <= wlast_err + 1;
      if (m_wlast) begin wr_act <= 0; bv <= 1; end
    end
    if (bv && m_bready) bv <= 0;
  end

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [3:0] s,
                        input logic [31:0] d, output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wstrb = s; req_wdata = d;
    #1;
    while (!req_accept && n < 5000) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid == 1'b1, "R9 response one cycle after accept", 32'(resp_valid), 32'd1);
    rd = resp_rdata;
    if (we)
      for (int b = 0; b < 4; b++)
        if (s[b]) ref_m[a[14:2]][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic rd_chk(input logic [31:0] a, input string req);
    logic [31:0] r;
    access(0, a, 4'h0, 32'h0, r);
    chk(r == ref_m[a[14:2]], req, r, ref_m[a[14:2]]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, x;
    int a0, w0;
    for (int i = 0; i < 8192; i++) begin mem[i] = seed_word(i); ref_m[i] = seed_word(i); end
    repeat (3) @(negedge clk);
    chk(!req_accept && !resp_valid && !m_arvalid && !m_awvalid && !m_wvalid, "R1 idle in reset",
        {27'd0, req_accept, resp_valid, m_arvalid, m_awvalid, m_wvalid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!req_accept && !resp_valid && !m_arvalid && !m_awvalid && !m_wvalid, "R1 idle after reset",
        {27'd0, req_accept, resp_valid, m_arvalid, m_awvalid, m_wvalid}, 32'd0);

    // R3 load miss fill
    a0 = ar_cnt;
    rd_chk(32'h104, "R3 miss data");
    chk(ar_cnt == a0 + 1, "R3 one burst", 32'(ar_cnt - a0), 32'd1);
    chk(last_arlen == 8'(LW - 1) && last_arburst == 2'b01, "R3 burst shape",
        {22'd0, last_arburst, last_arlen}, {22'd0, 2'b01, 8'(LW - 1)});
    chk(last_araddr == 32'h100, "R3 line address", last_araddr, 32'h100);
    // R2 hits over the whole line
    a0 = ar_cnt;
    for (int w = 0; w < LW; w++) rd_chk(32'h100 + 32'(4 * w), "R2 hit data");
    chk(ar_cnt == a0, "R2 no bus on hit", 32'(ar_cnt - a0), 32'd0);
    // R4 store hit, no write-through
    w0 = aw_cnt;
    access(1, 32'h108, 4'b0110, 32'haabb_ccdd, r);
    rd_chk(32'h108, "R4 merged bytes");
    chk(aw_cnt == w0 && mem[32'h108 >> 2] == seed_word(32'h108 >> 2), "R4 no write-through",
        mem[32'h108 >> 2], seed_word(32'h108 >> 2));
    // R7 invalid way preferred
    rd_chk(32'h180, "R7 second way fill");
    a0 = ar_cnt;
    rd_chk(32'h108, "R7 first line kept");
    chk(ar_cnt == a0, "R7 invalid way chosen", 32'(ar_cnt - a0), 32'd0);
    // R6 clean victim (0x180 is LRU)
    w0 = aw_cnt;
    rd_chk(32'h200, "R6 fill over clean");
    chk(aw_cnt == w0, "R6 no writeback", 32'(aw_cnt - w0), 32'd0);
    a0 = ar_cnt;
    rd_chk(32'h100, "R7 recent line kept");
    chk(ar_cnt == a0, "R7 LRU victim", 32'(ar_cnt - a0), 32'd0);
    // evict 0x200 (clean), then 0x100 (dirty)
    rd_chk(32'h180, "R7 refill");
    w0 = aw_cnt;
    rd_chk(32'h204, "R5 fill after writeback");
    chk(aw_cnt == w0 + 1, "R5 one writeback", 32'(aw_cnt - w0), 32'd1);
    chk(last_awaddr == 32'h100 && last_awlen == 8'(LW - 1), "R5 writeback shape",
        last_awaddr, 32'h100);
    for (int w = 0; w < LW; w++)
      chk(mem[64 + w] == ref_m[64 + w], "R5 memory after writeback", mem[64 + w], ref_m[64 + w]);
    // R4 store miss allocates
    a0 = ar_cnt; w0 = aw_cnt;
    access(1, 32'h294, 4'b1001, 32'h1122_3344, r);
    chk(ar_cnt == a0 + 1 && aw_cnt == w0, "R4 store miss allocate", 32'(ar_cnt - a0), 32'd1);
    rd_chk(32'h294, "R4 store miss merge");
    rd_chk(32'h290, "R4 neighbour word");
    // R8 uncached
    a0 = ar_cnt;
    rd_chk(32'h4012, "R8 uncached load");
    chk(last_arlen == 0 && last_araddr == 32'h4010, "R8 single beat", last_araddr, 32'h4010);
    rd_chk(32'h4010, "R8 repeat load");
    chk(ar_cnt == a0 + 2, "R8 no allocation", 32'(ar_cnt - a0), 32'd2);
    w0 = aw_cnt;
    access(1, 32'h4010, 4'b0101, 32'hdead_beef, r);
    chk(aw_cnt == w0 + 1 && last_awlen == 0, "R8 single store", 32'(aw_cnt - w0), 32'd1);
    chk(mem[32'h4010 >> 2] == ref_m[32'h4010 >> 2], "R8 strobed bytes",
        mem[32'h4010 >> 2], ref_m[32'h4010 >> 2]);
    rd_chk(32'h3ffc, "R8 top of window");
    chk(last_arlen == 8'(LW - 1), "R8 top cached", 32'(last_arlen), 32'(LW - 1));
    rd_chk(32'h4000, "R8 just outside");
    chk(last_arlen == 0, "R8 outside single", 32'(last_arlen), 32'd0);
    // sweep over conflicting lines
    x = 32'h1357_9bdf;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ad;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      ad = (x[20] ? 32'h4000 : 32'h0) | {21'd0, x[10:2], 2'b00};
      if (x[0]) access(1, ad, x[7:4], x ^ 32'h0f0f_0f0f, r);
      else rd_chk(ad, "R2 R4 R5 sweep read");
    end
    chk(acc_err == 0, "R9 accept while bus busy", 32'(acc_err), 32'd0);
    chk(ord_err == 0, "R5 fill after write response", 32'(ord_err), 32'd0);
    chk(wlast_err == 0, "R5 wlast placement", 32'(wlast_err), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule